// File: doc/BRIEF.md
# Chip-Enable-Latched Memory Host Sequencer

This block sits between a simple request/ready user port and an external parallel memory that captures its address when chip enable goes low. Each accepted request becomes exactly one bus cycle: an address and write-enable setup phase with chip enable high, an access phase with chip enable low, a one-cycle end phase in which chip enable rises, and a precharge phase with chip enable held high. Every phase length comes from a clock-count parameter.

Reads and writes use the same phase lengths, so every transfer occupies the bus for the same number of clocks. Writes are terminated by the rising edge of chip enable while write enable is already low. Because the memory finishes a write within the bus cycle, no polling follows it. A new request is taken as soon as the sequencer is back in its idle state.

Top module: `celatch_mem_host`

## Requirements
- R1: After reset, chip enable, write enable and output enable are high (inactive), the data drive enable is low, ready is high and rdata_valid is low.
- R2: A request is accepted only on a clock edge where ready and req are both high. Ready is high only in the idle state. After an accept, ready stays low for exactly SETUP_CYC + ACC_CYC + 1 + PRE_CYC clocks for both reads and writes. A req held high while ready is low starts no bus cycle.
- R3: The bus address is loaded at accept and does not change while chip enable is low. Chip enable falls only after SETUP_CYC clocks with the address already driven.
- R4: For a write, write enable is low before chip enable falls and stays low through the clock in which chip enable rises. Output enable stays high, and the data drive enable is high with the write data stable from the setup phase through that rise.
- R5: Chip enable stays low for exactly ACC_CYC = max(T_ACCESS, T_HOLD, T_DSETUP) clocks on every transfer, and never longer than T_CEMAX clocks.
- R6: For a read, output enable is low in exactly the clocks in which chip enable is low, and the data drive enable is low. Read data is captured on the last access clock. rdata_valid then pulses high for one clock, SETUP_CYC + ACC_CYC clocks after the accept edge.
- R7: Between two low periods, chip enable stays high for at least PRE_CYC + 1 clocks.
- R8: After a write, the next request is accepted with no status polling, as soon as ready returns high.
- R9: The data drive enable is never high while output enable is low. It is low in the clock before output enable falls.
- R10: Data written to any address reads back unchanged from a memory that latches its address on the chip-enable falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Transfer request |
| wr | input | 1 | 1 = write, 0 = read, sampled with req |
| addr | input | AW | Transfer address |
| wdata | input | DW | Write data |
| ready | output | 1 | High when a request can be accepted |
| rdata | output | DW | Captured read data |
| rdata_valid | output | 1 | One-clock pulse when rdata is new |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | AW | Memory address |
| mem_dout | output | DW | Data toward memory |
| mem_din | input | DW | Data from memory |
| mem_dout_en | output | 1 | Drive enable for mem_dout |

## Verification
The bench builds the block with a 4-bit address, SETUP_CYC=1, T_ACCESS=3, T_HOLD=2, T_DSETUP=2, PRE_CYC=2 and T_CEMAX=8. This keeps the whole address space of 16 locations small enough to sweep fully, with writes back to back, reads back to back, and write-then-read pairs at every address. Because T_ACCESS is the largest of the three access terms, the derived access length and every cycle count in the bench can be worked out by hand. A bus-side model latches the address on the chip-enable fall and commits the write on the rise, while a monitor measures the low and high run lengths and the enable ordering on every transfer.

// File: rtl/celatch_mem_host.sv
module celatch_mem_host #(
  parameter int AW        = 13,
  parameter int DW        = 8,
  parameter int SETUP_CYC = 1,
  parameter int T_ACCESS  = 4,
  parameter int T_HOLD    = 2,
  parameter int T_DSETUP  = 2,
  parameter int PRE_CYC   = 3,
  parameter int T_CEMAX   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          ready,
  output logic [DW-1:0] rdata,
  output logic          rdata_valid,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dout,
  input  logic [DW-1:0] mem_din,
  output logic          mem_dout_en
);

  localparam int ACC_A   = (T_ACCESS > T_HOLD) ? T_ACCESS : T_HOLD;
  localparam int ACC_CYC = (ACC_A > T_DSETUP) ? ACC_A : T_DSETUP;
  localparam int BIG0    = (ACC_CYC > SETUP_CYC) ? ACC_CYC : SETUP_CYC;
  localparam int BIG1    = (BIG0 > PRE_CYC) ? BIG0 : PRE_CYC;
  localparam int BIG     = (BIG1 > T_CEMAX) ? BIG1 : T_CEMAX;
  localparam int CW      = $clog2(BIG + 2) + 1;
  localparam logic [CW-1:0] CSAT = {CW{1'b1}};

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_ACCESS, S_END, S_PRE} state_t;

  state_t        st;
  logic [CW-1:0] cnt;
  logic          op_wr;
  logic          in_wr_cycle;

  assign in_wr_cycle = op_wr && (st == S_SETUP || st == S_ACCESS || st == S_END);
  assign ready       = (st == S_IDLE);
  assign mem_ce_n    = (st != S_ACCESS);
  assign mem_we_n    = !in_wr_cycle;
  assign mem_oe_n    = !(!op_wr && st == S_ACCESS);
  assign mem_dout_en = in_wr_cycle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      op_wr       <= 1'b0;
      mem_addr    <= '0;
      mem_dout    <= '0;
      rdata       <= '0;
      rdata_valid <= 1'b0;
    end else begin
      rdata_valid <= 1'b0;
      case (st)
        S_IDLE: if (req) begin
          mem_addr <= addr;
          mem_dout <= wdata;
          op_wr    <= wr;
          cnt      <= '0;
          st       <= S_SETUP;
        end
        S_SETUP: if (cnt == CW'(SETUP_CYC - 1)) begin
          cnt <= '0;
          st  <= S_ACCESS;
        end else cnt <= cnt + 1'b1;
        S_ACCESS: if (cnt == CW'(ACC_CYC - 1)) begin
          cnt <= '0;
          st  <= S_END;
          if (!op_wr) begin
            rdata       <= mem_din;
            rdata_valid <= 1'b1;
          end
        end else cnt <= cnt + 1'b1;
        S_END: begin
          cnt <= '0;
          st  <= S_PRE;
        end
        S_PRE: if (cnt == CW'(PRE_CYC - 1)) begin
          cnt <= '0;
          st  <= S_IDLE;
        end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [CW-1:0] lo_run, hi_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_run <= '0;
      hi_run <= CSAT;
    end else if (mem_ce_n) begin
      lo_run <= '0;
      hi_run <= (hi_run == CSAT) ? CSAT : hi_run + 1'b1;
    end else begin
      hi_run <= '0;
      lo_run <= (lo_run == CSAT) ? CSAT : lo_run + 1'b1;
    end
  end

  a_r2_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> mem_ce_n && mem_we_n && mem_oe_n && !mem_dout_en);
  a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
  a_r4_we_before_ce: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> $stable(mem_we_n) && $stable(mem_dout));
  a_r4_we_holds_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_ce_n) && $past(!mem_we_n)) |-> !mem_we_n && $stable(mem_dout));
  a_r4_oe_off_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);
  a_r5_ce_low_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce_n) |-> lo_run == CW'(ACC_CYC));
  a_r5_ce_max: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> lo_run < CW'(T_CEMAX));
  a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_valid |=> !rdata_valid);
  a_r7_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> hi_run >= CW'(PRE_CYC + 1));
  a_r9_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dout_en && $past(!mem_dout_en));

endmodule

// File: tb/tb_celatch_mem_host.sv
module tb_celatch_mem_host;
  localparam int AW = 4, DW = 8;
  localparam int SU = 1, TA = 3, TH = 2, TD = 2, PRE = 2, CEMAX = 8;
  localparam int ACC = 3;
  localparam int RV_AT = SU + ACC;
  localparam int BUSY = SU + ACC + 1 + PRE;

  logic clk = 0, rst_n = 0;
  logic req = 0, wr = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic ready, rdata_valid, ce_n, we_n, oe_n, den;
  logic [DW-1:0] rdata, dout, din;
  logic [AW-1:0] maddr;

  int checks = 0, fails = 0, cycles = 0;
  always #5 clk = ~clk;

  celatch_mem_host #(.AW(AW), .DW(DW), .SETUP_CYC(SU), .T_ACCESS(TA), .T_HOLD(TH),
    .T_DSETUP(TD), .PRE_CYC(PRE), .T_CEMAX(CEMAX)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .ready(ready), .rdata(rdata), .rdata_valid(rdata_valid), .mem_ce_n(ce_n),
    .mem_we_n(we_n), .mem_oe_n(oe_n), .mem_addr(maddr), .mem_dout(dout),
    .mem_din(din), .mem_dout_en(den));

  logic [DW-1:0] mem [16];
  logic [AW-1:0] lat_a;
  logic lat_w;
  int ce_falls = 0;
  always @(negedge ce_n) if (rst_n) begin
    lat_a = maddr; lat_w = !we_n; ce_falls++;
  end
  always @(posedge ce_n) if (rst_n && lat_w && den) mem[lat_a] = dout;
  assign din = (!ce_n && !oe_n) ? mem[lat_a] : '0;

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  logic p_ce = 1, p_we = 1, p_oe = 1, p_den = 0;
  logic [AW-1:0] p_addr;
  int lo = 0, hi = 1000;
  always @(negedge clk) if (rst_n) begin
    if (p_ce && !ce_n) begin
      chk(hi >= PRE + 1, "R7 precharge high run", hi, PRE + 1);
      chk(we_n == p_we, "R4 we settled before ce fall", we_n, p_we);
      chk(hi >= SU, "R3 address setup before ce fall", hi, SU);
    end
    if (!p_ce && ce_n) begin
      chk(lo == ACC, "R5 ce low length", lo, ACC);
      chk(lo <= CEMAX, "R5 ce max", lo, CEMAX);
    end
    if (!p_ce && !ce_n) chk(maddr == p_addr, "R3 address held", maddr, p_addr);
    if (!ce_n && !we_n) chk(oe_n && den, "R4 oe high and data driven", {oe_n, den}, 3);
    if (!p_ce && ce_n && !p_we) chk(!we_n && den, "R4 we low at ce rise", we_n, 0);
    if (!ce_n && we_n) chk(!oe_n && !den, "R6 read enables", {oe_n, den}, 0);
    if (p_oe && !oe_n) chk(!p_den, "R9 drive released before oe", p_den, 0);
    if (ce_n) begin hi++; lo = 0; end else begin lo++; hi = 0; end
    p_ce = ce_n; p_we = we_n; p_oe = oe_n; p_den = den; p_addr = maddr;
  end

  function automatic logic [7:0] pat1(input int a); return 8'(a * 37 + 5); endfunction
  function automatic logic [7:0] pat2(input int a); return 8'(a) ^ 8'hA5; endfunction

  task automatic op(input bit w, input int a, input logic [7:0] d,
                    input logic [7:0] exp, input bit noise);
    int k, rv_k, f0;
    while (!ready) @(negedge clk);
    chk(ready, "R8 ready without polling", ready, 1);
    f0 = ce_falls;
    req = 1; wr = w; addr = AW'(a); wdata = d;
    @(negedge clk);
    if (noise) begin addr = ~AW'(a); wdata = ~d; end else req = 0;
    k = 0; rv_k = -1;
    while (!ready && k < 50) begin
      if (rdata_valid) begin
        chk(rv_k < 0, "R6 single valid pulse", k, rv_k);
        rv_k = k;
        chk(rdata == exp, "R10 read data", rdata, exp);
      end
      @(negedge clk); k++;
    end
    req = 0;
    chk(k == BUSY, "R2 busy length", k, BUSY);
    chk(ce_falls - f0 == 1, "R2 one bus cycle per accept", ce_falls - f0, 1);
    if (w) chk(rv_k < 0, "R6 no valid on write", rv_k, -1);
    else chk(rv_k == RV_AT, "R6 valid timing", rv_k, RV_AT);
  endtask

  initial begin
    while (cycles < 100000) begin @(posedge clk); cycles++; end
    chk(0, "watchdog", cycles, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (2) @(negedge clk);
    chk(ready && ce_n && we_n && oe_n && !den && !rdata_valid, "R1 reset outputs",
        {ready, ce_n, we_n, oe_n, den, rdata_valid}, 6'b111100);
    rst_n = 1;
    @(negedge clk);
    chk(ready && ce_n && !den, "R1 idle after reset", {ready, ce_n, den}, 3'b110);
    for (int a = 0; a < 16; a++) op(1, a, pat1(a), 0, a[0]);
    for (int a = 0; a < 16; a++) op(0, a, 0, pat1(a), a[1]);
    for (int a = 15; a >= 0; a--) begin
      op(1, a, pat2(a), 0, 0);
      op(0, a, 0, pat2(a), 0);
    end
    for (int a = 0; a < 16; a++) op(0, a, 0, pat2(a), 0);
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule